// File: doc/BRIEF.md
# Byte-Steered Converter Read Port

This block is the read side of a 12-bit converter. A conversion engine hands it a held result word, an out-of-range flag and a busy indication. The block places the result and the flag on a shared bus whenever the port is selected and its output enable is asserted. The bus can be read in one of two ways:

- A 12-bit reader takes the whole word in one access.
- An 8-bit reader wired to the top eight lanes takes two accesses, steered by a byte-select input. The first access returns the upper eight bits. The second returns the bottom four bits on the top four of those lanes, with zeros below them.

Tri-state behaviour is represented by a value vector plus an enable vector, one enable bit per lane. The flag output has its own enable. The busy indication is passed through on an interrupt line that is always driven, whatever the select and enable inputs are doing.

The port is purely combinational and has no clock. Select, enable and byte-select may therefore change at any moment, independently of the conversion in progress, and the outputs follow within the same cycle. A read begins when the later of chip select and output enable goes low. It ends when the first of them goes high.

Top module: `conv_read_port`

## Requirements
- R1: While `cs_n` is 1, every bit of `bus_en` and `flag_en` is 0, for every value of `oe_n`, `byte_hi`, `word_in`, `flag_in` and `busy_in`.
- R2: While `cs_n` is 0 and `oe_n` is 1, every bit of `bus_en` and `flag_en` is 0.
- R3: While `cs_n` and `oe_n` are both 0, every bit of `bus_en` is 1 and `flag_en` is 1.
- R4: While the port is enabled and `byte_hi` is 0, `bus_out` equals `word_in` bit for bit (bit 11 is the MSB), so the top eight lanes carry data bits 11..4.
- R5: While the port is enabled and `byte_hi` is 1, `bus_out[11:8]` equals `word_in[3:0]` and `bus_out[7:0]` is all zero.
- R6: While the port is enabled, `flag_out` equals `flag_in` in both byte modes.
- R7: While the port is not enabled, `bus_out` and `flag_out` are all zero, so a floating lane never carries stale data.
- R8: `irq` equals `busy_in` at all times, for every combination of `cs_n`, `oe_n` and `byte_hi`; it has no enable.
- R9: All outputs settle within the same cycle as an input change, with no clock, so byte-select and enable changes take effect at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cs_n | input | 1 | Port select, active low; overrides the other controls |
| oe_n | input | 1 | Output enable, active low |
| byte_hi | input | 1 | Byte select: 0 gives the whole word or upper byte, 1 gives the low nibble |
| word_in | input | 12 | Held conversion result |
| flag_in | input | 1 | Held out-of-range flag |
| busy_in | input | 1 | Conversion-in-progress indication |
| bus_out | output | 12 | Bus lane values |
| bus_en | output | 12 | Per-lane drive enables |
| flag_out | output | 1 | Out-of-range flag value |
| flag_en | output | 1 | Flag drive enable |
| irq | output | 1 | Always-driven busy/interrupt line |

## Verification
Because there is no stored state, any fault shows at the ports in the same cycle as the input that exposes it. Three kinds of fault are covered:

- An inverted or mis-gated select shows as enables raised while `cs_n` or `oe_n` is high.
- A wrong lane map shows as the nibble on the wrong lanes, or as non-zero padding.
- A gated interrupt shows as `irq` departing from `busy_in` while the port is deselected.

The sweep covers every result word under every control combination, so a fault on a single lane is caught.

// File: rtl/conv_read_port.sv
module conv_read_port #(
  parameter int WORD_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              byte_hi,
  input  logic [WORD_W-1:0] word_in,
  input  logic              flag_in,
  input  logic              busy_in,
  output logic [WORD_W-1:0] bus_out,
  output logic [WORD_W-1:0] bus_en,
  output logic              flag_out,
  output logic              flag_en,
  output logic              irq
);
  localparam int NIB_W = WORD_W - BYTE_W;
  localparam int PAD_W = WORD_W - NIB_W;

  logic              rd_on;
  logic [WORD_W-1:0] lane_sel;

  assign rd_on = ~cs_n & ~oe_n;

  always_comb begin
    if (byte_hi) lane_sel = {word_in[NIB_W-1:0], {PAD_W{1'b0}}};
    else         lane_sel = word_in;
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_lane
    assign bus_en[i]  = rd_on;
    assign bus_out[i] = rd_on & lane_sel[i];
  end

  assign flag_en  = rd_on;
  assign flag_out = rd_on & flag_in;
  assign irq      = busy_in;

  always_comb begin
    if (!$isunknown({cs_n, oe_n, byte_hi, busy_in})) begin
      p_float_r1: assert (!(cs_n && (bus_en != '0 || flag_en)))
        else $error("cs_n high yet lanes driven");
      p_oe_off_r2: assert (!(!cs_n && oe_n && (bus_en != '0 || flag_en)))
        else $error("oe_n high yet lanes driven");
      p_enable_r3: assert (!(!cs_n && !oe_n && (bus_en != '1 || !flag_en)))
        else $error("read selected yet lanes not driven");
      p_pad_zero_r5: assert (!(flag_en && byte_hi && bus_out[PAD_W-1:0] != '0))
        else $error("low-byte padding not zero");
      p_quiet_r7: assert (!(!flag_en && (bus_out != '0 || flag_out)))
        else $error("undriven lanes carry data");
      p_irq_r8: assert (irq == busy_in)
        else $error("irq not following busy");
    end
  end
endmodule

// File: tb/sim_conv_read_port.sv
module sim_conv_read_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        cs_n, oe_n, byte_hi, flag_in, busy_in;
  logic [11:0] word_in;
  logic [11:0] bus_out, bus_en;
  logic        flag_out, flag_en, irq;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_read_port u0 (
    .cs_n(cs_n), .oe_n(oe_n), .byte_hi(byte_hi), .word_in(word_in),
    .flag_in(flag_in), .busy_in(busy_in), .bus_out(bus_out), .bus_en(bus_en),
    .flag_out(flag_out), .flag_en(flag_en), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (cs_n=%0b oe_n=%0b byte_hi=%0b word=%0h)",
               req, act, exp, cs_n, oe_n, byte_hi, word_in);
    end
  endtask

  initial begin
    logic        on;
    logic [11:0] exp_bus;
    cs_n = 1; oe_n = 1; byte_hi = 0; word_in = '0; flag_in = 0; busy_in = 0;
    #2;
    check("R1 idle enables", {bus_en, flag_en}, 0);
    check("R7 idle values", {bus_out, flag_out}, 0);
    for (int w = 0; w < 4096; w++) begin
      for (int c = 0; c < 32; c++) begin
        cs_n = c[0]; oe_n = c[1]; byte_hi = c[2]; flag_in = c[3]; busy_in = c[4];
        word_in = w[11:0];
        #1;
        on = !cs_n && !oe_n;
        check("R8 irq", irq, busy_in);
        if (cs_n)      check("R1 float", {bus_en, flag_en}, 0);
        else if (oe_n) check("R2 float", {bus_en, flag_en}, 0);
        else           check("R3 drive", {bus_en, flag_en}, 13'h1fff);
        if (!on) begin
          check("R7 quiet", {bus_out, flag_out}, 0);
        end else begin
          exp_bus = byte_hi ? ((w % 16) * 256) : w[11:0];
          if (byte_hi) check("R5 low byte", bus_out, exp_bus);
          else         check("R4 word", bus_out, exp_bus);
          check("R6 flag", flag_out, flag_in);
        end
      end
    end
    cs_n = 0; oe_n = 0; byte_hi = 0; word_in = 12'hA5C; flag_in = 1; busy_in = 1;
    #1 check("R9 word now", bus_out, 12'hA5C);
    byte_hi = 1;
    #1 check("R9 byte flip", bus_out, 12'hC00);
    oe_n = 1;
    #1 check("R9 enable drop", {bus_en, flag_en}, 0);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done) begin
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end else if (cycles >= WATCHDOG) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule